// File: doc/BRIEF.md
# Tagged Two-Bit Branch Direction Predictor

This block guesses the direction of conditional branches for an instruction fetch unit. It is a direct-mapped table. Each entry holds a valid flag, an address tag and a two-bit saturating counter. In the fetch cycle the front end presents an instruction word address on the lookup port. Within the same cycle it gets back a hit flag and a taken/not-taken guess. When no entry matches, the block reports "no prediction" and the guess falls back to not-taken.

When a branch resolves in the execute stage, its word address and real direction arrive on the update port. A matching entry moves its counter one step toward the real direction. A non-matching entry is claimed for the new branch, and any older branch at that index is evicted. One cycle after each update, the block reports which of four cases the branch fell into. The four cases are: predicted and correct, predicted and wrong, defaulted and correct, and defaulted and wrong.

The counter is a four-state machine. The states are strong-not-taken (00), weak-not-taken (01), weak-taken (10) and strong-taken (11). The transitions are:
- taken-step: moves one state upward, and stays at strong-taken once there.
- not-taken-step: moves one state downward, and stays at strong-not-taken once there.
- allocate: sets the entry to weak-taken for a taken branch, or to weak-not-taken for a not-taken branch.

The classifier has two states, idle and report. It enters report on the cycle after any update and returns to idle when no update follows.

Top module: `bp_table`

## Requirements
- R1: The entry index is `pc[IDX_W-1:0]` and the tag is `pc[PC_W-1:IDX_W]`. A lookup hits only when the indexed entry is valid and its stored tag equals the tag bits. A different tag at the same index is a miss.
- R2: On a miss, `lk_hit` is 0 and `lk_taken` is 0 (default not-taken).
- R3: An update that misses allocates the entry. The counter starts at weak-taken (10) if `up_taken` is 1, or weak-not-taken (01) otherwise. The address hits from the following cycle.
- R4: An update that hits increments the counter on taken, saturating at 11. It decrements the counter on not-taken, saturating at 00.
- R5: On a hit, `lk_taken` is the counter's most significant bit. Starting from a strong state, the guess flips only after two consecutive opposing outcomes.
- R6: One cycle after each update, `cls_valid` is 1 and `cls_code` reports the case:
  - 00: hit, correct.
  - 01: hit, wrong.
  - 10: miss, and the not-taken default was correct.
  - 11: miss, and the not-taken default was wrong.
  
  Without an update, `cls_valid` is 0 in the following cycle.
- R7: When a lookup and an update address the same entry in one cycle, the lookup returns the state from before the update. The new state is visible in the next cycle.
- R8: Reset clears every valid flag, so every lookup misses afterwards and `cls_valid` is 0.
- R9: An allocating update whose tag differs from the stored one replaces the entry, and the old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch word address to look up |
| lk_hit | output | 1 | A matching entry exists |
| lk_taken | output | 1 | Predicted direction (0 on miss) |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | PC_W | Word address of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |
| cls_valid | output | 1 | Classification of the previous update is valid |
| cls_code | output | 2 | Outcome case, encoded as in R6 |

## Verification
The bench builds the table with `PC_W = 12` and `IDX_W = 4`. This gives 16 entries and an 8-bit tag. Two addresses that differ only in the tag fall on the same entry, which makes both tag mismatch and eviction easy to reach. One address is driven through every counter state, including both saturation ends, and the two-step direction change is observed in both directions. A lookup that collides with an update in the same cycle is also covered.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef enum logic [1:0] {
        CLS_HIT_OK  = 2'b00,
        CLS_HIT_BAD = 2'b01,
        CLS_DEF_OK  = 2'b10,
        CLS_DEF_BAD = 2'b11
    } cls_e;
endpackage

// File: rtl/bp_pc_split.sv
module bp_pc_split #(
    parameter int PC_W  = 30,
    parameter int IDX_W = 10,
    parameter int TAG_W = PC_W - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    assign idx = pc[IDX_W-1:0];
    assign tag = pc[PC_W-1:IDX_W];
endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
    import bp_pkg::*;
(
    input  ctr_e cur,
    input  logic alloc,
    input  logic taken,
    output ctr_e nxt
);
    always_comb begin
        nxt = cur;
        if (alloc) begin
            nxt = taken ? CTR_WT : CTR_WNT;
        end else begin
            unique case (cur)
                CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
                CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
                CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
                CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
                default: nxt = CTR_WNT;
            endcase
        end
    end
endmodule

// File: rtl/bp_classify.sv
module bp_classify
    import bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       hit,
    input  logic       pred,
    input  logic       taken,
    output logic       cls_valid,
    output logic [1:0] cls_code
);
    typedef enum logic {ST_IDLE = 1'b0, ST_REPORT = 1'b1} cst_e;

    cst_e st_q, st_d;
    cls_e code_q, code_d;

    always_comb begin
        st_d   = upd ? ST_REPORT : ST_IDLE;
        code_d = code_q;
        if (upd) begin
            unique case ({hit, pred == taken})
                2'b11:   code_d = CLS_HIT_OK;
                2'b10:   code_d = CLS_HIT_BAD;
                2'b01:   code_d = CLS_DEF_OK;
                default: code_d = CLS_DEF_BAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            code_q <= CLS_HIT_OK;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_REPORT: cls_valid = 1'b1;
            default:   cls_valid = 1'b0;
        endcase
        cls_code = code_q;
    end
endmodule

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int PC_W  = 30,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    output logic            cls_valid,
    output logic [1:0]      cls_code
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    ctr_e               ctr_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;

    bp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_split (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );
    bp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_split (
        .pc(up_pc), .idx(up_idx), .tag(up_tag)
    );

    // Fetch-side read: combinational, sees state before any same-cycle write
    ctr_e lk_ctr;
    always_comb begin
        lk_ctr   = ctr_q[lk_idx];
        lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_taken = lk_hit && lk_ctr[1];
    end

    // Resolve-side read of the same table
    ctr_e up_ctr, up_nxt;
    logic up_hit, up_pred;
    always_comb begin
        up_ctr  = ctr_q[up_idx];
        up_hit  = vld_q[up_idx] && (tag_q[up_idx] == up_tag);
        up_pred = up_hit && up_ctr[1];
    end

    bp_ctr_next u_next (
        .cur(up_ctr), .alloc(!up_hit), .taken(up_taken), .nxt(up_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (up_valid && !up_hit) begin
            vld_q[up_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && up_valid) begin
            tag_q[up_idx] <= up_tag;
            ctr_q[up_idx] <= up_nxt;
        end
    end

    bp_classify u_cls (
        .clk(clk), .rst_n(rst_n), .upd(up_valid), .hit(up_hit),
        .pred(up_pred), .taken(up_taken),
        .cls_valid(cls_valid), .cls_code(cls_code)
    );
endmodule

// File: rtl/bp_table_chk.sv
module bp_table_chk #(
    parameter int PC_W = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic            lk_taken,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken,
    input logic            cls_valid,
    input logic [1:0]      cls_code
);
    a_r2_miss_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> !lk_taken);

    a_r3_update_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (lk_pc != $past(up_pc)) || lk_hit);

    a_r6_report_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> cls_valid);

    a_r6_quiet_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> !cls_valid);

    a_r6_code_matches_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lk_pc == up_pc) |=>
            cls_code == {!$past(lk_hit), $past(lk_taken) != $past(up_taken)});

    a_r8_report_cleared: assert property (@(posedge clk)
        !rst_n |=> !cls_valid);
endmodule

bind bp_table bp_table_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_taken(lk_taken), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .cls_valid(cls_valid), .cls_code(cls_code)
);

// File: tb/tb_bp_table.sv
module tb_bp_table;
    localparam int PC_W  = 12;
    localparam int IDX_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_hit, lk_taken;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    logic            cls_valid;
    logic [1:0]      cls_code;

    always #4 clk = ~clk;

    bp_table #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .cls_valid(cls_valid), .cls_code(cls_code)
    );

    // Same index 0, tags 1 and 2; PC_C is index 1
    localparam logic [PC_W-1:0] PC_A = 12'h010;
    localparam logic [PC_W-1:0] PC_B = 12'h020;
    localparam logic [PC_W-1:0] PC_C = 12'h011;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_q [$];
    string      req_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [PC_W-1:0] pc, input logic eh,
                          input logic et, input string req);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check(lk_hit == eh, req, "lk_hit", int'(lk_hit), int'(eh));
        check(lk_taken == et, req, "lk_taken", int'(lk_taken), int'(et));
    endtask

    task automatic update(input logic [PC_W-1:0] pc, input logic t,
                          input logic [1:0] code, input string req);
        @(negedge clk);
        up_valid = 1'b1;
        up_pc    = pc;
        up_taken = t;
        exp_q.push_back(code);
        req_q.push_back(req);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    // Monitor: pops expected classifications as the design reports them
    always @(posedge clk) begin
        #2;
        if (cls_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected cls_valid", 1, 0);
            end else begin
                automatic logic [1:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                check(cls_code == e, r, "cls_code", int'(cls_code), int'(e));
            end
        end
    end

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 / R2: empty after reset
        lookup(PC_A, 1'b0, 1'b0, "R8");
        lookup(PC_C, 1'b0, 1'b0, "R2");
        check(cls_valid == 1'b0, "R8", "cls_valid after reset", int'(cls_valid), 0);

        // R3: allocate taken -> weak-taken; default NT was wrong
        update(PC_A, 1'b1, 2'b11, "R6");
        lookup(PC_A, 1'b1, 1'b1, "R3");
        check(cls_valid == 1'b0, "R6", "cls_valid idle", int'(cls_valid), 0);
        // R4: climb and saturate at 11
        update(PC_A, 1'b1, 2'b00, "R6");
        update(PC_A, 1'b1, 2'b00, "R4");
        // R5: one NT from strong-taken keeps taken
        update(PC_A, 1'b0, 2'b01, "R6");
        lookup(PC_A, 1'b1, 1'b1, "R5");
        // R5: second NT flips
        update(PC_A, 1'b0, 2'b01, "R5");
        lookup(PC_A, 1'b1, 1'b0, "R5");
        // R4: down to 00 and saturate
        update(PC_A, 1'b0, 2'b00, "R4");
        update(PC_A, 1'b0, 2'b00, "R4");
        update(PC_A, 1'b1, 2'b01, "R4");
        lookup(PC_A, 1'b1, 1'b0, "R4");
        // R5: second taken from the low end flips to taken
        update(PC_A, 1'b1, 2'b01, "R5");
        lookup(PC_A, 1'b1, 1'b1, "R5");

        // R1: same index, other tag misses
        lookup(PC_B, 1'b0, 1'b0, "R1");
        // R9: allocating PC_B evicts PC_A; R3 not-taken alloc -> weak-NT
        update(PC_B, 1'b0, 2'b10, "R6");
        lookup(PC_B, 1'b1, 1'b0, "R3");
        lookup(PC_A, 1'b0, 1'b0, "R9");
        // R1: other index is independent
        update(PC_C, 1'b0, 2'b10, "R3");
        lookup(PC_C, 1'b1, 1'b0, "R3");
        lookup(PC_B, 1'b1, 1'b0, "R1");

        // R7: same-cycle lookup and update on PC_B (counter 01 -> 10)
        @(negedge clk);
        lk_pc    = PC_B;
        up_valid = 1'b1;
        up_pc    = PC_B;
        up_taken = 1'b1;
        exp_q.push_back(2'b01);
        req_q.push_back("R7");
        #1;
        check(lk_hit == 1'b1, "R7", "old lk_hit", int'(lk_hit), 1);
        check(lk_taken == 1'b0, "R7", "old lk_taken", int'(lk_taken), 0);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        check(lk_taken == 1'b1, "R7", "new lk_taken", int'(lk_taken), 1);

        // R8: reset mid-run clears everything
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lookup(PC_B, 1'b0, 1'b0, "R8");
        lookup(PC_C, 1'b0, 1'b0, "R8");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6", "pending classifications", exp_q.size(), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", "timeout", 1, 0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule